// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Interrupt Detection

This block is a general-purpose I/O peripheral with eight pins on a simple byte-wide register bus. Software sets each pin as an input or an output and drives output levels through a data window. In that window the address holds a per-bit mask, so a single pin can be read or changed without a read-modify-write sequence. Each pin input goes through a synchroniser before any logic reads it.

Each pin has its own interrupt detector. Three per-pin configuration bits choose how it senses: edge or level, one edge or both edges, and the active polarity. Edge events stay latched until software clears them through a write-one-to-clear register. Level events follow the pin directly. The block reports raw and masked status, and one interrupt line combines every enabled source.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is 0.
- R2: A write to byte offsets 0x000-0x3FC changes only the output bits whose mask bit is set in address bits [9:2]. The other output bits keep their value.
- R3: A read of the data window returns 0 in unmasked bits. In a masked bit it returns the output register bit when the pin is an output, and the synchronised input otherwise. An input change can be read from the third rising clock edge after it is applied.
- R4: The direction register at offset 0x400 drives `pin_oe` directly. A 1 makes the pin an output, and the register reads back what was written.
- R5: With the sense bit (offset 0x404) at 0, a pin detects edges. Event bit (offset 0x40C) 1 selects rising edges and 0 selects falling edges. A detected edge sets that pin's raw status bit (offset 0x414), and the bit stays set.
- R6: With the both-edges bit (offset 0x408) at 1 on an edge-sensed pin, rising and falling edges both set status, and the event bit has no effect.
- R7: With the sense bit at 1, raw status equals the synchronised level when the event bit is 1, and its inverse when the event bit is 0. Clear writes do not change it.
- R8: Writing 1 to a bit at offset 0x41C clears that pin's latched edge status, and writing 0 leaves it unchanged. If a new edge is detected in the same cycle as the clear, the status stays set.
- R9: The interrupt mask at offset 0x410 (1 = enabled) reads back as written. The masked status at offset 0x418 equals raw status AND mask.
- R10: `irq` is 1 exactly when at least one masked status bit is 1.
- R11: The register at offset 0x420 is plain read/write storage. Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while bus_en is high |
| pin_in | input | 8 | Asynchronous pin input levels |
| pin_out | output | 8 | Output levels |
| pin_oe | output | 8 | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that configuration bits do not change in the cycle where an edge is being latched or cleared. They also assume that bus accesses last one cycle with the address held stable. The bench writes configuration only while the pin inputs are quiet, and it changes `pin_in` only on falling clock edges. Every pin change is followed by three rising edges before any status is sampled, except for the one test that deliberately lines up a clear with a newly detected edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // word indices (byte offset >> 2) of the control registers
  localparam int WIX_DIR   = 'h100;
  localparam int WIX_SENSE = 'h101;
  localparam int WIX_BOTH  = 'h102;
  localparam int WIX_EVT   = 'h103;
  localparam int WIX_MASK  = 'h104;
  localparam int WIX_RAW   = 'h105;
  localparam int WIX_MSTAT = 'h106;
  localparam int WIX_CLR   = 'h107;
  localparam int WIX_MODE  = 'h108;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH, SEL_EVT,
    SEL_MASK, SEL_RAW, SEL_MSTAT, SEL_CLR, SEL_MODE
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] st_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) st_q <= 2'b00;
    else         st_q <= {st_q[0], 1'b1};
  end

  assign srst_n = st_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= {st_q[STAGES-2:0], d};
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic lvl_prev,
  input  logic sense,
  input  logic both,
  input  logic polarity,
  input  logic clr,
  output logic raw
);
  logic rise, fall, edge_hit, lat_q, lat_d;

  assign rise = lvl & ~lvl_prev;
  assign fall = ~lvl & lvl_prev;

  always_comb begin
    if (both)          edge_hit = rise | fall;
    else if (polarity) edge_hit = rise;
    else               edge_hit = fall;
  end

  // latched edge status; held clear while the pin is level-sensed
  always_comb begin
    lat_d = ~sense & (edge_hit | (lat_q & ~clr));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;
  end

  assign raw = sense ? (polarity ? lvl : ~lvl) : lat_q;

  // R8
  clr_vs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && edge_hit && !sense) |=> lat_q);

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clr && !sense) |=> lat_q);

  // R8
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && clr && !edge_hit) |=> !lat_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPIN        = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  import gpio_pkg::*;

  localparam int WORD_W = ADDR_W - 2;
  localparam int WIN_HI = NPIN + 2;

  logic              rst_s_n;
  logic [NPIN-1:0]   pin_s, pin_d_q;
  logic [NPIN-1:0]   out_q, dir_q, sense_q, both_q, evt_q, mask_q, mode_q;
  logic [NPIN-1:0]   out_d, amask, clr, raw, mstat;
  logic [WORD_W-1:0] word;
  logic              in_window, wr, addr_lo_unused;
  reg_sel_e          sel;

  gpio_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .d(pin_in), .q(pin_s)
  );

  // address decode
  assign addr_lo_unused = ^bus_addr[1:0];
  assign word      = bus_addr[ADDR_W-1:2];
  assign amask     = bus_addr[WIN_HI-1:2];
  assign in_window = (bus_addr[ADDR_W-1:WIN_HI] == '0);
  assign wr        = bus_en & bus_we;

  always_comb begin
    sel = SEL_NONE;
    if (in_window) sel = SEL_DATA;
    else begin
      case (int'(word))
        WIX_DIR:   sel = SEL_DIR;
        WIX_SENSE: sel = SEL_SENSE;
        WIX_BOTH:  sel = SEL_BOTH;
        WIX_EVT:   sel = SEL_EVT;
        WIX_MASK:  sel = SEL_MASK;
        WIX_RAW:   sel = SEL_RAW;
        WIX_MSTAT: sel = SEL_MSTAT;
        WIX_CLR:   sel = SEL_CLR;
        WIX_MODE:  sel = SEL_MODE;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  // next state
  always_comb begin
    out_d = (out_q & ~amask) | (bus_wdata & amask);
    clr   = (wr && sel == SEL_CLR) ? bus_wdata : '0;
  end

  // register file with explicit write enables
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      evt_q   <= '0;
      mask_q  <= '0;
      mode_q  <= '0;
      pin_d_q <= '0;
    end else begin
      pin_d_q <= pin_s;
      if (wr && sel == SEL_DATA)  out_q   <= out_d;
      if (wr && sel == SEL_DIR)   dir_q   <= bus_wdata;
      if (wr && sel == SEL_SENSE) sense_q <= bus_wdata;
      if (wr && sel == SEL_BOTH)  both_q  <= bus_wdata;
      if (wr && sel == SEL_EVT)   evt_q   <= bus_wdata;
      if (wr && sel == SEL_MASK)  mask_q  <= bus_wdata;
      if (wr && sel == SEL_MODE)  mode_q  <= bus_wdata;
    end
  end

  // per-pin interrupt detectors
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio_pin_irq u_pin (
      .clk(clk), .rst_n(rst_s_n),
      .lvl(pin_s[i]), .lvl_prev(pin_d_q[i]),
      .sense(sense_q[i]), .both(both_q[i]), .polarity(evt_q[i]),
      .clr(clr[i]), .raw(raw[i])
    );
  end

  assign mstat = raw & mask_q;
  assign irq   = |mstat;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_en) begin
      case (sel)
        SEL_DATA:  bus_rdata = amask & ((dir_q & out_q) | (~dir_q & pin_s));
        SEL_DIR:   bus_rdata = dir_q;
        SEL_SENSE: bus_rdata = sense_q;
        SEL_BOTH:  bus_rdata = both_q;
        SEL_EVT:   bus_rdata = evt_q;
        SEL_MASK:  bus_rdata = mask_q;
        SEL_RAW:   bus_rdata = raw;
        SEL_MSTAT: bus_rdata = mstat;
        SEL_MODE:  bus_rdata = mode_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R2
  data_mask_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr && sel == SEL_DATA) |=> (((pin_out ^ $past(pin_out)) & ~$past(amask)) == '0));

  // R4
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr && sel == SEL_DIR) |=> (pin_oe == $past(bus_wdata)));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mask_q == '0) |-> !irq);

  // R7
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sense_q[0] && evt_q[0]) |-> (raw[0] == pin_s[0]));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic        irq;
  int          nvec = 0;
  int          nerr = 0;
  bit          done = 0;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] v);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 v = bus_rdata;
    bus_en = 0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, expo, pv, lat, rawx, msk, c, pins;
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    for (int k = 0; k <= 8; k++) begin
      rd(12'h400 + 12'(4*k), v);
      chk("R1 reg", v, 8'h00);
    end

    // R4 direction
    wr(12'h400, 8'hFF);
    chk("R4 oe", pin_oe, 8'hFF);
    rd(12'h400, v); chk("R4 rb", v, 8'hFF);

    // R2 every address mask
    expo = 8'h00;
    for (int m = 0; m < 256; m++) begin
      logic [7:0] wd;
      wd = 8'(m * 7) ^ 8'h96;
      wr(12'(m << 2), wd);
      expo = (expo & ~8'(m)) | (wd & 8'(m));
      chk("R2 out", pin_out, expo);
    end
    rd(12'h3FC, v); chk("R2 rb", v, expo);

    // R3 mixed direction reads
    wr(12'h400, 8'h0F);
    wr(12'h3FC, 8'hA6);
    for (int p = 0; p < 3; p++) begin
      pins = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'h5C;
      pin_in = pins;
      settle();
      for (int m = 0; m < 256; m++) begin
        rd(12'(m << 2), v);
        chk("R3 rd", v, 8'(m) & ((8'h0F & 8'hA6) | (8'hF0 & pins)));
      end
    end

    // R11 mode storage and unmapped offsets
    wr(12'h420, 8'h3C);
    rd(12'h420, v); chk("R11 mode", v, 8'h3C);
    wr(12'h424, 8'hFF);
    rd(12'h424, v); chk("R11 unmapped", v, 8'h00);
    rd(12'h400, v); chk("R11 dir kept", v, 8'h0F);
    rd(12'h420, v); chk("R11 mode kept", v, 8'h3C);
    wr(12'h400, 8'h00);

    // R5 R6 R7 R8 R9 R10 mode sweep: 0 rise,1 fall,2 both,3 high,4 low
    for (int md = 0; md < 5; md++) begin
      logic lvl_mode;
      lvl_mode = (md >= 3);
      pv = 8'h33;
      pin_in = pv;
      settle();
      wr(12'h404, lvl_mode ? 8'hFF : 8'h00);
      wr(12'h408, (md == 2) ? 8'hFF : 8'h00);
      wr(12'h40C, (md == 2) ? 8'hA5 : ((md == 0 || md == 3) ? 8'hFF : 8'h00));
      wr(12'h41C, 8'hFF);
      lat = 8'h00;
      for (int s = 0; s < 16; s++) begin
        logic [7:0] nv;
        nv = 8'(pv * 5 + 8'(s * 29) + 3);
        pin_in = nv;
        settle();
        case (md)
          0: lat = lat | (nv & ~pv);
          1: lat = lat | (~nv & pv);
          2: lat = lat | (nv ^ pv);
          default: ;
        endcase
        rawx = (md == 3) ? nv : (md == 4) ? ~nv : lat;
        rd(12'h414, v);
        chk(lvl_mode ? "R7 raw" : (md == 2 ? "R6 raw" : "R5 raw"), v, rawx);
        msk = 8'(s * 53) ^ 8'hC3;
        wr(12'h410, msk);
        rd(12'h410, v); chk("R9 mask", v, msk);
        rd(12'h418, v); chk("R9 masked", v, rawx & msk);
        chk("R10 irq", {7'b0, irq}, {7'b0, |(rawx & msk)});
        c = 8'(s * 37) ^ 8'h5A;
        wr(12'h41C, c);
        if (!lvl_mode) lat = lat & ~c;
        rawx = (md == 3) ? nv : (md == 4) ? ~nv : lat;
        rd(12'h414, v);
        chk(lvl_mode ? "R7 noclr" : "R8 clr", v, rawx);
        pv = nv;
      end
    end

    // R8 edge arriving with the clear wins
    wr(12'h404, 8'h00); wr(12'h408, 8'h00); wr(12'h40C, 8'hFF);
    pin_in = 8'h00;
    settle();
    wr(12'h41C, 8'hFF);
    wr(12'h410, 8'h01);
    pin_in = 8'h01;
    @(negedge clk);
    @(negedge clk);
    wr(12'h41C, 8'h01);
    @(negedge clk);
    rd(12'h414, v); chk("R8 same-cycle", v, 8'h01);
    chk("R10 irq set", {7'b0, irq}, 8'h01);
    wr(12'h41C, 8'h00);
    rd(12'h414, v); chk("R8 zero write", v, 8'h01);
    wr(12'h41C, 8'h01);
    rd(12'h414, v); chk("R8 cleared", v, 8'h00);
    chk("R10 irq clear", {7'b0, irq}, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule